// File: doc/BRIEF.md
# Assertion Run-Stop Event Controller

This block gathers the fire lines of a fixed set of hard-coded hardware assertion checkers. It links them into a scan-based run-stop debug scheme. The assertions sit in equal-sized enable groups, and each group has one enable bit. A fire from a disabled group has no effect. Each assertion has a class, error or warning, which is set by a parameter vector.

An enabled error fire sets a sticky halt request that behaves like a hardware breakpoint. It stays set until the debugger clears it. Every enabled fire, error or warning, sets a sticky bit in a status register. The bit only records that the assertion fired, not how many times.

The debugger reaches the block through a small scan port with three commands. Capture copies the status into a shift chain and clears the status. Shift moves the chain one bit per clock toward the scan output. Update loads the group enables from the chain.

Top module: `asrt_stop_ctrl`

## Requirements
- R1: After reset `halt_o` is 0, every status bit and chain bit is 0, and every group enable equals `GRP_EN_RST` (default all ones).
- R2: When an enabled assertion whose `ERR_MASK` bit is 1 (error) fires at a clock edge, `halt_o` is 1 from that edge on.
- R3: When an enabled assertion whose `ERR_MASK` bit is 0 (warning) fires, it sets its status bit and never raises `halt_o`.
- R4: A fire from an assertion whose group enable is 0 sets no status bit and does not raise `halt_o`.
- R5: `halt_o` stays 1 until an edge with `halt_clr_i` high and no enabled error fire in that cycle, even after the error line drops.
- R6: A status bit stays set until a capture. At a capture edge the chain takes the current status, and the status is cleared. A fire in the capture cycle stays set for the next read.
- R7: At a shift edge without capture, chain bit k takes bit k+1, bit N-1 takes `scan_in_i`, and `scan_out_o` always shows chain bit 0. Capture takes priority over shift. After N shifts, chain bit k holds the k-th bit shifted in, counting from 0.
- R8: At an update edge, the enable of group g takes chain bit g.
- R9: Repeated fires of one assertion before a capture leave that assertion's single status bit set and change no other bit.
- R10: Assertion i belongs to group i / (N_ASRT / N_GRP), and its class is bit i of `ERR_MASK`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fire_i | input | N_ASRT | Fire lines from the assertion checkers |
| scan_capture_i | input | 1 | Copy status into the chain and clear status |
| scan_shift_i | input | 1 | Shift the chain one bit toward `scan_out_o` |
| scan_update_i | input | 1 | Load the group enables from the low chain bits |
| scan_in_i | input | 1 | Serial data into the top of the chain |
| halt_clr_i | input | 1 | Clear the halt request |
| scan_out_o | output | 1 | Serial data from chain bit 0 |
| halt_o | output | 1 | Sticky halt request to the clock-stopping logic |

## Verification
Each fire pattern is tried with its group enabled and then disabled. The patterns are a single one-cycle warning, a single one-cycle error, and a whole group firing together. The results separate the gating by group from the error/warning class. Repeated fires of one assertion show that the status records only that it fired. A fire in the same cycle as a capture shows whether the clear loses a new event. A halt clear during a quiet period is set against one during an active error. Full read-and-write scan transfers, and one cycle with capture and shift high together, check the order of the chain bits and the capture priority.

// File: rtl/asrt_pkg.sv
package asrt_pkg;
  typedef enum logic [1:0] {
    SCAN_IDLE    = 2'd0,
    SCAN_CAPTURE = 2'd1,
    SCAN_SHIFT   = 2'd2
  } scan_op_e;
endpackage

// File: rtl/asrt_gate.sv
module asrt_gate #(
  parameter int unsigned N_ASRT = 16,
  parameter int unsigned N_GRP  = 4,
  parameter logic [N_ASRT-1:0] ERR_MASK = '0
) (
  input  logic [N_ASRT-1:0] fire_i,
  input  logic [N_GRP-1:0]  grp_en_i,
  output logic [N_ASRT-1:0] fire_eff_o,
  output logic              err_hit_o
);
  localparam int unsigned GRP_SIZE = N_ASRT / N_GRP;

  logic [N_ASRT-1:0] en_exp;

  for (genvar i = 0; i < N_ASRT; i++) begin : g_map
    assign en_exp[i] = grp_en_i[i / GRP_SIZE];
  end

  assign fire_eff_o = fire_i & en_exp;
  assign err_hit_o  = |(fire_eff_o & ERR_MASK);
endmodule

// File: rtl/asrt_status.sv
module asrt_status #(
  parameter int unsigned N_ASRT = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_ASRT-1:0] fire_eff_i,
  input  logic              err_hit_i,
  input  logic              capture_i,
  input  logic              halt_clr_i,
  output logic [N_ASRT-1:0] status_o,
  output logic              halt_o
);
  logic [N_ASRT-1:0] status_q;
  logic              halt_q;

  // capture clears, but a fire in the same cycle survives
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else if (capture_i) status_q <= fire_eff_i;
    else status_q <= status_q | fire_eff_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) halt_q <= 1'b0;
    else if (err_hit_i) halt_q <= 1'b1;
    else if (halt_clr_i) halt_q <= 1'b0;
  end

  assign status_o = status_q;
  assign halt_o   = halt_q;
endmodule

// File: rtl/asrt_scan.sv
module asrt_scan
  import asrt_pkg::*;
#(
  parameter int unsigned N_ASRT = 16,
  parameter int unsigned N_GRP  = 4,
  parameter logic [N_GRP-1:0] GRP_EN_RST = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              capture_i,
  input  logic              shift_i,
  input  logic              update_i,
  input  logic              scan_in_i,
  input  logic [N_ASRT-1:0] status_i,
  output logic [N_ASRT-1:0] chain_o,
  output logic [N_GRP-1:0]  grp_en_o,
  output logic              scan_out_o
);
  scan_op_e          op;
  logic [N_ASRT-1:0] chain_q;
  logic [N_GRP-1:0]  grp_en_q;

  always_comb begin
    if (capture_i)    op = SCAN_CAPTURE;
    else if (shift_i) op = SCAN_SHIFT;
    else              op = SCAN_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else begin
      unique case (op)
        SCAN_CAPTURE: chain_q <= status_i;
        SCAN_SHIFT:   chain_q <= {scan_in_i, chain_q[N_ASRT-1:1]};
        default:      chain_q <= chain_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) grp_en_q <= GRP_EN_RST;
    else if (update_i) grp_en_q <= chain_q[N_GRP-1:0];
  end

  assign chain_o    = chain_q;
  assign grp_en_o   = grp_en_q;
  assign scan_out_o = chain_q[0];
endmodule

// File: rtl/asrt_stop_ctrl.sv
module asrt_stop_ctrl #(
  parameter int unsigned N_ASRT = 16,
  parameter int unsigned N_GRP  = 4,
  parameter logic [N_ASRT-1:0] ERR_MASK   = 16'h0F0F,
  parameter logic [N_GRP-1:0]  GRP_EN_RST = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_ASRT-1:0] fire_i,
  input  logic              scan_capture_i,
  input  logic              scan_shift_i,
  input  logic              scan_update_i,
  input  logic              scan_in_i,
  input  logic              halt_clr_i,
  output logic              scan_out_o,
  output logic              halt_o
);
  logic [N_ASRT-1:0] fire_eff;
  logic              err_hit;
  logic [N_ASRT-1:0] status_q;
  logic [N_ASRT-1:0] chain_q;
  logic [N_GRP-1:0]  grp_en_q;

  asrt_gate #(.N_ASRT(N_ASRT), .N_GRP(N_GRP), .ERR_MASK(ERR_MASK)) u_gate (
    .fire_i     (fire_i),
    .grp_en_i   (grp_en_q),
    .fire_eff_o (fire_eff),
    .err_hit_o  (err_hit)
  );

  asrt_status #(.N_ASRT(N_ASRT)) u_status (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fire_eff_i (fire_eff),
    .err_hit_i  (err_hit),
    .capture_i  (scan_capture_i),
    .halt_clr_i (halt_clr_i),
    .status_o   (status_q),
    .halt_o     (halt_o)
  );

  asrt_scan #(.N_ASRT(N_ASRT), .N_GRP(N_GRP), .GRP_EN_RST(GRP_EN_RST)) u_scan (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .capture_i  (scan_capture_i),
    .shift_i    (scan_shift_i),
    .update_i   (scan_update_i),
    .scan_in_i  (scan_in_i),
    .status_i   (status_q),
    .chain_o    (chain_q),
    .grp_en_o   (grp_en_q),
    .scan_out_o (scan_out_o)
  );
endmodule

// File: rtl/asrt_stop_ctrl_chk.sv
module asrt_stop_ctrl_chk #(
  parameter int unsigned N_ASRT = 16,
  parameter int unsigned N_GRP  = 4,
  parameter logic [N_ASRT-1:0] ERR_MASK = '0
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [N_ASRT-1:0] fire_i,
  input logic              capture_i,
  input logic              shift_i,
  input logic              update_i,
  input logic              halt_clr_i,
  input logic              scan_out_o,
  input logic              halt_o,
  input logic [N_ASRT-1:0] status,
  input logic [N_ASRT-1:0] chain,
  input logic [N_GRP-1:0]  grp_en
);
  localparam int unsigned GRP_SIZE = N_ASRT / N_GRP;

  logic [N_ASRT-1:0] en_exp;
  for (genvar i = 0; i < N_ASRT; i++) begin : g_en
    assign en_exp[i] = grp_en[i / GRP_SIZE];
  end

  logic err_on;
  assign err_on = |(fire_i & en_exp & ERR_MASK);

  // R2
  err_halt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_on |=> halt_o);

  // R3
  no_spur_halt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!halt_o && !err_on) |=> !halt_o);

  // R5
  halt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_o && !halt_clr_i) |=> halt_o);

  // R6
  status_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !capture_i |=> ((status & $past(status)) == $past(status)));

  // R6
  capture_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture_i |=> (chain == $past(status)));

  // R7
  shift_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_i && !capture_i) |=> (scan_out_o == $past(chain[1])));

  // R8
  update_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    update_i |=> (grp_en == $past(chain[N_GRP-1:0])));
endmodule

bind asrt_stop_ctrl asrt_stop_ctrl_chk #(
  .N_ASRT(N_ASRT), .N_GRP(N_GRP), .ERR_MASK(ERR_MASK)
) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .fire_i     (fire_i),
  .capture_i  (scan_capture_i),
  .shift_i    (scan_shift_i),
  .update_i   (scan_update_i),
  .halt_clr_i (halt_clr_i),
  .scan_out_o (scan_out_o),
  .halt_o     (halt_o),
  .status     (status_q),
  .chain      (chain_q),
  .grp_en     (grp_en_q)
);

// File: tb/asrt_stop_ctrl_tb_top.sv
module asrt_stop_ctrl_tb_top;
  localparam int N = 16;
  localparam int G = 4;
  localparam int GS = N / G;
  localparam logic [N-1:0] EMASK = 16'h0F0F;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] fire = '0;
  logic cap = 0, sh = 0, upd = 0, sin = 0, hclr = 0;
  logic sout, halt;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 0;

  logic [N-1:0] m_st, m_ch;
  logic [G-1:0] m_en;
  logic         m_halt;

  always #2 clk = ~clk;

  asrt_stop_ctrl #(.N_ASRT(N), .N_GRP(G), .ERR_MASK(EMASK)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .fire_i(fire),
    .scan_capture_i(cap), .scan_shift_i(sh), .scan_update_i(upd),
    .scan_in_i(sin), .halt_clr_i(hclr),
    .scan_out_o(sout), .halt_o(halt)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // behavioural model, one clock edge
  task automatic model_edge();
    logic [N-1:0] eff;
    logic [N-1:0] st_old, ch_old;
    logic         err;
    for (int i = 0; i < N; i++) eff[i] = fire[i] & m_en[i / GS];
    err = 1'b0;
    for (int i = 0; i < N; i++) if (eff[i] && EMASK[i]) err = 1'b1;
    st_old = m_st;
    ch_old = m_ch;
    m_st = cap ? eff : (m_st | eff);
    if (err) m_halt = 1'b1;
    else if (hclr) m_halt = 1'b0;
    if (cap) m_ch = st_old;
    else if (sh) begin
      for (int k = 0; k < N - 1; k++) m_ch[k] = ch_old[k + 1];
      m_ch[N-1] = sin;
    end
    if (upd) for (int g = 0; g < G; g++) m_en[g] = ch_old[g];
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk("R2/R5 halt", {31'd0, halt}, {31'd0, m_halt});
    chk("R7 scan_out", {31'd0, sout}, {31'd0, m_ch[0]});
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  // capture, N shifts reading out and writing in, then update
  task automatic scan_xfer(input logic [N-1:0] win, output logic [N-1:0] rd);
    cap = 1; step(); cap = 0;
    for (int k = 0; k < N; k++) begin
      rd[k] = sout;
      sh = 1; sin = win[k]; step();
    end
    sh = 0; sin = 0;
    upd = 1; step(); upd = 0;
  endtask

  task automatic pulse(input logic [N-1:0] f);
    fire = f; step(); fire = '0;
  endtask

  initial begin
    logic [N-1:0] rd;
    m_st = '0; m_ch = '0; m_en = '1; m_halt = 0;
    repeat (3) @(negedge clk);
    chk("R1 halt in reset", {31'd0, halt}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 scan_out after reset", {31'd0, sout}, 32'd0);
    scan_xfer(16'h000F, rd);
    chk("R1 status after reset", rd, 32'h0);

    // warning in group 1
    pulse(16'h0010);
    idle(2);
    chk("R3 warning no halt", {31'd0, halt}, 32'd0);
    scan_xfer(16'h000F, rd);
    chk("R3 warning status", rd, 32'h0010);

    // error in group 0
    pulse(16'h0002);
    chk("R2 error halts", {31'd0, halt}, 32'd1);
    idle(3);
    chk("R5 halt held", {31'd0, halt}, 32'd1);
    hclr = 1; step(); hclr = 0;
    chk("R5 halt cleared", {31'd0, halt}, 32'd0);
    scan_xfer(16'h000F, rd);
    chk("R10 error status bit", rd, 32'h0002);

    // clear while an error fires: halt stays
    fire = 16'h0100; hclr = 1; step(); fire = '0; hclr = 0;
    chk("R5 clear loses to fire", {31'd0, halt}, 32'd1);
    hclr = 1; step(); hclr = 0;
    chk("R5 halt cleared again", {31'd0, halt}, 32'd0);
    scan_xfer(16'h000E, rd);
    chk("R10 group2 error status", rd, 32'h0100);

    // group 0 disabled
    pulse(16'h000F);
    idle(1);
    chk("R4 disabled no halt", {31'd0, halt}, 32'd0);
    scan_xfer(16'h000F, rd);
    chk("R4 disabled no status", rd, 32'h0);

    // repeated fires
    pulse(16'h0020); idle(1); pulse(16'h0020); pulse(16'h0020);
    scan_xfer(16'h000F, rd);
    chk("R9 single bit on repeats", rd, 32'h0020);

    // fire in the capture cycle
    pulse(16'h0080);
    fire = 16'h0040; cap = 1; step(); fire = '0; cap = 0;
    chk("R6 capture gets old status", {31'd0, sout}, 32'd0);
    scan_xfer(16'h000F, rd);
    chk("R6 capture-cycle fire kept", rd, 32'h0040);

    // update disables group 3
    scan_xfer(16'h0007, rd);
    pulse(16'h1000);
    scan_xfer(16'h000F, rd);
    chk("R8 group3 disabled", rd, 32'h0);
    pulse(16'h1000);
    scan_xfer(16'h000F, rd);
    chk("R8 group3 re-enabled", rd, 32'h1000);

    // capture priority over shift, and shift ordering
    pulse(16'h0001);
    hclr = 1; step(); hclr = 0;
    cap = 1; sh = 1; sin = 1; step(); cap = 0; sh = 0; sin = 0;
    chk("R7 capture over shift", {31'd0, sout}, 32'd1);
    for (int k = 0; k < N; k++) begin
      sh = 1; sin = (k == 3); step();
    end
    sh = 0; sin = 0;
    idle(3);
    chk("R7 shifted bit 0 at out", {31'd0, sout}, 32'd0);
    for (int k = 0; k < 3; k++) begin
      sh = 1; step();
    end
    sh = 0;
    chk("R7 shifted bit 3 at out", {31'd0, sout}, 32'd1);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule